// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the master side of a serial peripheral interface link. A single go strobe starts a transaction. The engine loads a transmit word and shifts it out on MOSI. At the same time it captures a receive word from MISO. It produces the serial clock, drives slave select, and returns the captured word on a parallel output. The word length can be set from 1 to 32 bits. The following can also be chosen:

- the clock idle level;
- the clock edge type that changes MOSI;
- the clock edge type that samples MISO;
- the bit order;
- the active level of slave select.

A transaction carries one word or two words. Between the two words of a burst, the engine waits for a programmed number of extra serial clock periods.

The configuration inputs are captured at the go strobe and hold for the whole transaction. The transmit words are inputs that stay on the bus: word 0 is taken at the start, and word 1 is taken when the first word ends. A write strobe marks that new transmit data has been supplied. The transmit-empty flag reports when a transaction has consumed that data and no newer data has arrived since.

Slave select has two styles. In level style it is held active for the whole transaction. In edge style it gives a single active pulse, one half serial period long, at the start of the transaction and then returns to inactive.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, `busy` is 0 and `tx_empty` is 1. While idle, `sclk` follows `cfg_cpol`, and `ss` sits at its inactive level. The inactive level is 1 when `cfg_ss_high` is 0, and 0 when `cfg_ss_high` is 1.
- R2: The word length N is `cfg_len`, except that a value of 0 means 32. Each word produces exactly 2N serial clock edges and transfers N bits in each direction.
- R3: With `cfg_lsb_first` at 0, bit N-1 goes first, both on MOSI and into the receive word. With it at 1, bit 0 goes first.
- R4: MOSI changes only on drive edges and MISO is sampled only on sample edges. A drive edge is falling when `cfg_drive_fall` is 1 and rising otherwise. A sample edge is falling when `cfg_sample_fall` is 1 and rising otherwise. The first bit is on MOSI before the first edge.
- R5: A half serial period lasts H system clocks, where H is `cfg_half`. A value of 0 counts as 1. Consecutive clock edges within a word are H cycles apart.
- R6: In level style (`cfg_ss_edge` = 0), `ss` becomes active in the cycle after go. It stays active until H cycles after the last edge. For one word, `busy` and active `ss` both last (2N+1)·H cycles.
- R7: In edge style (`cfg_ss_edge` = 1), `ss` is active only for the first H cycles of the transaction and then stays inactive.
- R8: With `cfg_two_words` = 1, a second word follows. The time from the last edge of word 0 to the first edge of word 1 is (2P+2)·H cycles, where P is `cfg_pause`. `busy` lasts (4N+2P+2)·H cycles in total.
- R9: `busy` rises in the cycle after a go strobe that arrives while idle. A go strobe that arrives while `busy` is high is ignored and does not change the transaction length.
- R10: `tx_wr` clears `tx_empty`. `tx_empty` returns to 1 in the cycle `busy` falls, but only if no `tx_wr` occurred since that transaction started. Otherwise it stays 0.
- R11: `rx_word0` and `rx_word1` change only at the end of their own word. In the middle of a word they keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_drive_fall | input | 1 | 1: MOSI changes on falling edges |
| cfg_sample_fall | input | 1 | 1: MISO sampled on falling edges |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_len | input | LEN_W | Word length, 0 means WORD_W |
| cfg_two_words | input | 1 | 1: two words per transaction |
| cfg_pause | input | PAUSE_W | Extra serial periods between the two words |
| cfg_ss_high | input | 1 | 1: slave select active high |
| cfg_ss_edge | input | 1 | 1: pulse-style slave select |
| cfg_half | input | DIV_W | System clocks per half serial period |
| tx_word0 | input | WORD_W | First transmit word |
| tx_word1 | input | WORD_W | Second transmit word |
| tx_wr | input | 1 | New transmit data strobe |
| go | input | 1 | Start strobe |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Transaction in progress |
| tx_empty | output | 1 | Transmit data consumed |
| rx_word0 | output | WORD_W | First received word |
| rx_word1 | output | WORD_W | Second received word |
| sclk | output | 1 | Serial clock |
| ss | output | 1 | Slave select |
| mosi | output | 1 | Serial data to the slave |

## Verification
Some properties are checked on every cycle:

- the idle levels of `sclk` and `ss`;
- `busy` starting after an idle go;
- `tx_empty` rising only as `busy` falls;
- the receive words never changing while idle.

Other behaviour can only be shown by the bench's transfers against a modelled slave:

- bit content and order on both data lines;
- the choice of edges;
- edge spacing and the pause between words;
- the slave-select styles;
- a go strobe ignored mid-transfer.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_BITS,
    PH_TRAIL,
    PH_GAP
  } phase_t;
endpackage

// File: rtl/spi_half_timer.sv
// Half-period tick generator: one-cycle tick every max(half,1) cycles while run.
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (half == '0) ? '0 : half - DIV_W'(1);
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_bit_lane.sv
// Transmit and receive shift registers with bit-order selection.
module spi_bit_lane #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  n,
  input  logic              lsb,
  input  logic              drive,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] tx_sh, tx_nx, rx_sh, mask;
  logic [IDX_W-1:0]  idx_top;
  logic              seen;

  assign idx_top = IDX_W'(n - CNT_W'(1));

  // A drive edge advances only once the current bit has been sampled.
  always_comb begin
    tx_nx = tx_sh;
    if (load) tx_nx = load_word;
    else if (drive && seen) tx_nx = lsb ? (tx_sh >> 1) : (tx_sh << 1);
  end

  always_comb begin
    mask = (n >= CNT_W'(WORD_W)) ? '1 : ((WORD_W'(1) << n) - WORD_W'(1));
    if (lsb) rx_word = rx_sh >> (CNT_W'(WORD_W) - n);
    else     rx_word = rx_sh & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
      seen  <= 1'b0;
      mosi  <= 1'b0;
    end else begin
      tx_sh <= tx_nx;
      mosi  <= lsb ? tx_nx[0] : tx_nx[idx_top];
      if (load) seen <= 1'b0;
      else if (sample) begin
        seen  <= 1'b1;
        rx_sh <= lsb ? {miso, rx_sh[WORD_W-1:1]} : {rx_sh[WORD_W-2:0], miso};
      end
    end
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
// Transaction sequencer: slave select, clock edges, word boundaries.
module spi_seq_ctrl
  import spi_eng_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 5,
  parameter int PAUSE_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               tick,
  input  logic               cfg_cpol,
  input  logic               cfg_drive_fall,
  input  logic               cfg_sample_fall,
  input  logic               cfg_lsb_first,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_two_words,
  input  logic [PAUSE_W-1:0] cfg_pause,
  input  logic               cfg_ss_high,
  input  logic               cfg_ss_edge,
  input  logic [DIV_W-1:0]   cfg_half,
  output logic               busy,
  output logic               sclk,
  output logic               ss,
  output logic               drive,
  output logic               sample,
  output logic               load,
  output logic               load_sel,
  output logic               fin,
  output logic               fin_sel,
  output logic               last_done,
  output logic               cur_lsb,
  output logic [LEN_W:0]     cur_n,
  output logic [DIV_W-1:0]   cur_half
);
  localparam int EC_W = LEN_W + 2;

  phase_t             ph;
  logic [EC_W-1:0]    ecnt;
  logic [PAUSE_W:0]   pcnt;
  logic [PAUSE_W-1:0] cur_pause;
  logic               cur_dfall, cur_sfall, cur_two, cur_sshigh, cur_ssedge, wsel;
  logic               edge_now, start;

  assign start     = (ph == PH_IDLE) && go;
  assign edge_now  = tick && ((ph == PH_LEAD) || (ph == PH_BITS));
  // sclk high now means this edge is a falling one.
  assign drive     = edge_now && (sclk ? cur_dfall : !cur_dfall);
  assign sample    = edge_now && (sclk ? cur_sfall : !cur_sfall);
  assign fin       = tick && (ph == PH_TRAIL);
  assign fin_sel   = wsel;
  assign last_done = fin && (!cur_two || wsel);
  assign load      = start || (fin && cur_two && !wsel);
  assign load_sel  = !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      busy <= 1'b0;
      sclk <= 1'b0;
      ss   <= 1'b1;
      ecnt <= '0;
      pcnt <= '0;
      wsel <= 1'b0;
      {cur_dfall, cur_sfall, cur_two, cur_sshigh, cur_ssedge, cur_lsb} <= '0;
      cur_n     <= '0;
      cur_half  <= '0;
      cur_pause <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          sclk <= cfg_cpol;
          ss   <= ~cfg_ss_high;
          if (go) begin
            ph         <= PH_LEAD;
            busy       <= 1'b1;
            ss         <= cfg_ss_high;
            wsel       <= 1'b0;
            cur_dfall  <= cfg_drive_fall;
            cur_sfall  <= cfg_sample_fall;
            cur_lsb    <= cfg_lsb_first;
            cur_two    <= cfg_two_words;
            cur_sshigh <= cfg_ss_high;
            cur_ssedge <= cfg_ss_edge;
            cur_pause  <= cfg_pause;
            cur_half   <= cfg_half;
            cur_n      <= (cfg_len == '0) ? (LEN_W+1)'(WORD_W) : {1'b0, cfg_len};
          end
        end
        PH_LEAD: if (tick) begin
          sclk <= ~sclk;
          ecnt <= EC_W'(1);
          ph   <= PH_BITS;
          if (cur_ssedge) ss <= ~cur_sshigh;
        end
        PH_BITS: if (tick) begin
          sclk <= ~sclk;
          ecnt <= ecnt + EC_W'(1);
          if (ecnt == ({cur_n, 1'b0} - EC_W'(1))) ph <= PH_TRAIL;
        end
        PH_TRAIL: if (tick) begin
          if (cur_two && !wsel) begin
            wsel <= 1'b1;
            pcnt <= {cur_pause, 1'b0};
            ph   <= (cur_pause == '0) ? PH_LEAD : PH_GAP;
          end else begin
            ph   <= PH_IDLE;
            busy <= 1'b0;
            ss   <= ~cur_sshigh;
          end
        end
        PH_GAP: if (tick) begin
          pcnt <= pcnt - (PAUSE_W+1)'(1);
          if (pcnt == (PAUSE_W+1)'(1)) ph <= PH_LEAD;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int WORD_W  = 32,
  parameter int LEN_W   = $clog2(WORD_W),
  parameter int PAUSE_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_cpol,
  input  logic               cfg_drive_fall,
  input  logic               cfg_sample_fall,
  input  logic               cfg_lsb_first,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_two_words,
  input  logic [PAUSE_W-1:0] cfg_pause,
  input  logic               cfg_ss_high,
  input  logic               cfg_ss_edge,
  input  logic [DIV_W-1:0]   cfg_half,
  input  logic [WORD_W-1:0]  tx_word0,
  input  logic [WORD_W-1:0]  tx_word1,
  input  logic               tx_wr,
  input  logic               go,
  input  logic               miso,
  output logic               busy,
  output logic               tx_empty,
  output logic [WORD_W-1:0]  rx_word0,
  output logic [WORD_W-1:0]  rx_word1,
  output logic               sclk,
  output logic               ss,
  output logic               mosi
);
  localparam int CNT_W = LEN_W + 1;

  logic              tick, drive, sample, load, load_sel, fin, fin_sel, last_done, cur_lsb;
  logic [CNT_W-1:0]  cur_n;
  logic [DIV_W-1:0]  cur_half;
  logic [WORD_W-1:0] lane_rx;
  logic              wr_seen;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .half(cur_half), .tick(tick)
  );

  spi_seq_ctrl #(
    .WORD_W(WORD_W), .LEN_W(LEN_W), .PAUSE_W(PAUSE_W), .DIV_W(DIV_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .go(go), .tick(tick),
    .cfg_cpol(cfg_cpol), .cfg_drive_fall(cfg_drive_fall),
    .cfg_sample_fall(cfg_sample_fall), .cfg_lsb_first(cfg_lsb_first),
    .cfg_len(cfg_len), .cfg_two_words(cfg_two_words), .cfg_pause(cfg_pause),
    .cfg_ss_high(cfg_ss_high), .cfg_ss_edge(cfg_ss_edge), .cfg_half(cfg_half),
    .busy(busy), .sclk(sclk), .ss(ss), .drive(drive), .sample(sample),
    .load(load), .load_sel(load_sel), .fin(fin), .fin_sel(fin_sel),
    .last_done(last_done), .cur_lsb(cur_lsb), .cur_n(cur_n), .cur_half(cur_half)
  );

  spi_bit_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lane (
    .clk(clk), .rst(rst), .load(load),
    .load_word(load_sel ? tx_word1 : tx_word0),
    .n(load_sel ? cur_n : ((cfg_len == '0) ? CNT_W'(WORD_W) : {1'b0, cfg_len})),
    .lsb(load_sel ? cur_lsb : cfg_lsb_first),
    .drive(drive), .sample(sample), .miso(miso),
    .mosi(mosi), .rx_word(lane_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word0 <= '0;
      rx_word1 <= '0;
      tx_empty <= 1'b1;
      wr_seen  <= 1'b0;
    end else begin
      if (fin && !fin_sel) rx_word0 <= lane_rx;
      if (fin &&  fin_sel) rx_word1 <= lane_rx;
      if (go && !busy) wr_seen <= 1'b0;
      if (tx_wr) begin
        wr_seen  <= 1'b1;
        tx_empty <= 1'b0;
      end
      if (last_done && !wr_seen && !tx_wr) tx_empty <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              go,
  input logic              busy,
  input logic              sclk,
  input logic              ss,
  input logic              cfg_cpol,
  input logic              cfg_ss_high,
  input logic              tx_empty,
  input logic [WORD_W-1:0] rx_word0,
  input logic [WORD_W-1:0] rx_word1
);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |=> busy);

  // R1
  idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(rst)) |-> (sclk == $past(cfg_cpol)));

  // R1
  idle_ss_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(rst)) |-> (ss == !$past(cfg_ss_high)));

  // R10
  empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> $fell(busy));

  // R11
  rx0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word0) |-> $past(busy));

  // R11
  rx1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word1) |-> $past(busy));
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .busy(busy), .sclk(sclk), .ss(ss),
  .cfg_cpol(cfg_cpol), .cfg_ss_high(cfg_ss_high), .tx_empty(tx_empty),
  .rx_word0(rx_word0), .rx_word1(rx_word1)
);

// File: tb/test_spi_xfer_master.sv
`timescale 1ns/1ps
module test_spi_xfer_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_cpol = 0, cfg_drive_fall = 0, cfg_sample_fall = 0, cfg_lsb_first = 0;
  logic [4:0]  cfg_len = 0;
  logic        cfg_two_words = 0, cfg_ss_high = 0, cfg_ss_edge = 0;
  logic [7:0]  cfg_pause = 0, cfg_half = 1;
  logic [31:0] tx_word0 = 0, tx_word1 = 0;
  logic        tx_wr = 0, go = 0, miso = 0;
  logic        busy, tx_empty, sclk, ss, mosi;
  logic [31:0] rx_word0, rx_word1;

  always #10 clk = ~clk;

  spi_xfer_master i_spi_xfer_master (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // scoreboard of expected MOSI words
  logic [31:0] exp_q[$];
  int t_n; bit t_lsb, t_sfall;
  logic [31:0] sw0, sw1, acc;
  int bc, sidx; bit swsel;
  int cyc = 0, busy_cyc, ss_cyc;
  int etime[$];
  logic prev_sclk = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  function automatic logic sbit(input logic [31:0] w, input int i, input int n, input bit lsb);
    return lsb ? w[i] : w[n-1-i];
  endfunction

  // monitor: slave model plus scoreboard pop
  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cyc++;
    if (ss == cfg_ss_high) ss_cyc++;
    if (busy && sclk !== prev_sclk) begin
      etime.push_back(cyc);
      if ((sclk == 1'b1) ? !t_sfall : t_sfall) begin
        if (t_lsb) acc[bc] = mosi; else acc = (acc << 1) | {31'b0, mosi};
        bc++;
        if (bc == t_n) begin
          if (exp_q.size() == 0) chk("R2 unexpected word", acc, 32'hx);
          else chk("R3 R4 mosi word", acc & mk(t_n), exp_q.pop_front());
          bc = 0; acc = 0;
        end
        sidx++;
        if (sidx == t_n) begin sidx = 0; swsel = 1; end
        miso = sbit(swsel ? sw1 : sw0, sidx, t_n, t_lsb);
      end
    end
    prev_sclk = sclk;
  end

  // driver: mid = 0 none, 1 extra go, 2 tx_wr, 3 rx hold check
  task automatic run_xfer(input bit cpol, input bit dfall, input bit lsb, input int len,
                          input bit two, input int pause, input bit ssh, input bit sse,
                          input int half, input logic [31:0] t0, input logic [31:0] t1,
                          input logic [31:0] s0, input logic [31:0] s1, input int mid);
    int n, h, exp_busy;
    logic [31:0] rx_before;
    n = (len == 0) ? 32 : len;
    h = (half == 0) ? 1 : half;
    @(negedge clk);
    cfg_cpol = cpol; cfg_drive_fall = dfall; cfg_sample_fall = !dfall;
    cfg_lsb_first = lsb; cfg_len = 5'(len); cfg_two_words = two;
    cfg_pause = 8'(pause); cfg_ss_high = ssh; cfg_ss_edge = sse; cfg_half = 8'(half);
    tx_word0 = t0; tx_word1 = t1;
    t_n = n; t_lsb = lsb; t_sfall = !dfall;
    sw0 = s0; sw1 = s1; bc = 0; acc = 0; sidx = 0; swsel = 0;
    miso = sbit(s0, 0, n, lsb);
    exp_q.push_back(t0 & mk(n));
    if (two) exp_q.push_back(t1 & mk(n));
    repeat (2) @(negedge clk);
    rx_before = rx_word0;
    busy_cyc = 0; ss_cyc = 0; etime.delete();
    go = 1; @(negedge clk); go = 0;
    repeat (n * h) @(negedge clk);
    if (mid == 1) begin go = 1; @(negedge clk); go = 0; end
    if (mid == 2) begin tx_wr = 1; @(negedge clk); tx_wr = 0; end
    if (mid == 3) chk("R11 rx0 held mid-word", rx_word0, rx_before);
    while (busy) @(negedge clk);
    @(negedge clk);
    exp_busy = two ? (4*n + 2 + 2*pause) * h : (2*n + 1) * h;
    chk("R6 R8 R9 busy length", busy_cyc, exp_busy);
    chk(sse ? "R7 ss pulse length" : "R6 ss active length", ss_cyc, sse ? h : exp_busy);
    chk("R2 edge count", etime.size(), two ? 4*n : 2*n);
    chk("R5 edge spacing", etime[1] - etime[0], h);
    if (two) chk("R8 word gap", etime[2*n] - etime[2*n-1], (2*pause + 2) * h);
    chk("R3 R4 rx_word0", rx_word0, s0 & mk(n));
    if (two) chk("R8 rx_word1", rx_word1, s1 & mk(n));
    chk("R10 tx_empty", tx_empty, (mid == 2) ? 0 : 1);
    chk("R1 idle sclk", sclk, cpol);
    chk("R1 idle ss", ss, !ssh);
    chk("R2 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset tx_empty", tx_empty, 1);
    chk("R1 reset ss", ss, 1);
    chk("R1 reset sclk", sclk, 0);
    tx_wr = 1; @(negedge clk); tx_wr = 0;
    chk("R10 cleared by write", tx_empty, 0);
    run_xfer(0, 1, 0, 8,  0, 0, 0, 0, 2, 32'hA5, 0, 32'h3C, 0, 0);
    run_xfer(1, 0, 1, 0,  0, 0, 1, 0, 3, 32'h1234_5678, 0, 32'hCAFE_F00D, 0, 0);
    run_xfer(0, 1, 0, 5,  1, 3, 0, 0, 2, 32'h13, 32'h0A, 32'h19, 32'h06, 0);
    run_xfer(0, 0, 0, 12, 0, 0, 0, 1, 2, 32'hABC, 0, 32'h5A3, 0, 0);
    run_xfer(1, 1, 1, 1,  0, 0, 1, 0, 1, 32'h1, 0, 32'h1, 0, 0);
    run_xfer(1, 0, 1, 16, 1, 0, 0, 0, 0, 32'hBEEF, 32'h1357, 32'hD00D, 32'h2468, 0);
    run_xfer(0, 1, 1, 9,  0, 0, 0, 0, 2, 32'h155, 0, 32'h0AA, 0, 1);
    tx_wr = 1; @(negedge clk); tx_wr = 0;
    run_xfer(0, 1, 0, 7,  0, 0, 0, 0, 2, 32'h55, 0, 32'h2A, 0, 2);
    run_xfer(1, 1, 0, 10, 0, 0, 1, 0, 2, 32'h3F0, 0, 32'h20F, 0, 3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule